// File: doc/BRIEF.md
# Serial EEPROM Single-Word Reader

This block is a bus master that pulls one 16-bit word out of an external three-wire serial EEPROM. The memory's data input and data output are tied together on one bidirectional line. On the host side a request carries an 8-bit word address over a valid/ready handshake. The answer comes back as a one-cycle response strobe that carries the 16-bit word.

On the memory side the block raises chip select and produces a serial clock from the system clock, using a divider that is set at run time. It shifts out a start bit, the read opcode and the address. It then stops driving the shared line and shifts in the returned word. Every word is fetched with a complete, separate frame, so the block never depends on the memory stepping its own address forward. Chip select is held low for at least one full serial clock period between frames.

Back-pressure rules: a request is taken on a cycle where `req_valid` and `req_ready` are both high. The host holds the address stable until that cycle. `req_ready` stays low from acceptance until the inter-frame gap has passed, and a request offered during that time has no effect. The response has no ready: `rsp_valid` is a single-cycle strobe that cannot be stalled. `rsp_data` keeps its value until the next request is accepted.

Top module: `spi3w_word_reader`

## Requirements
- R1: While reset is asserted and directly after it, `mem_cs`, `mem_sclk`, `mem_sio_oe` and `rsp_valid` are low and `req_ready` is high.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the gap of R10 ends, and requests offered while it is low do not change the frame being sent or the word returned.
- R3: Each frame starts with 11 outgoing bits, one per rising `mem_sclk` edge, in this order: start bit 1, opcode bit 1, opcode bit 0, then the 8 address bits most significant first.
- R4: `mem_cs` rises at least one half serial period (`sclk_div`+1 system cycles) before the first rising `mem_sclk` edge, and stays high for the whole frame.
- R5: `mem_sio_o` only changes in the cycle in which `mem_sclk` falls, or at acceptance. It is stable across every rising edge.
- R6: `mem_sio_oe` is high from acceptance through the 11th rising edge. It drops on the falling edge that follows the 11th rising edge and stays low for the rest of the frame.
- R7: The value on `mem_sio_i` at the 12th rising edge is discarded. The values at rising edges 13 to 28 form the word, most significant bit first.
- R8: The serial clock period is 2*(`sclk_div`+1) system cycles, and `mem_sclk` is low whenever `mem_cs` is low.
- R9: On the falling edge after the 28th rising edge, `mem_cs` drops and `rsp_valid` pulses for exactly one cycle with the word on `rsp_data`. `rsp_data` then holds until the next acceptance.
- R10: `req_ready` returns exactly 2*(`sclk_div`+1) cycles after the `rsp_valid` cycle. As a result, `mem_cs` stays low for more than one serial clock period before the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_div | input | 8 | Half period of serial clock minus one, in system cycles; change only while idle |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 8 | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe: word captured |
| rsp_data | output | 16 | Word read from the memory |
| mem_cs | output | 1 | Memory chip select, active high |
| mem_sclk | output | 1 | Serial clock to the memory |
| mem_sio_o | output | 1 | Outgoing value for the shared data line |
| mem_sio_oe | output | 1 | Drive enable for the shared data line |
| mem_sio_i | input | 1 | Value read back from the shared data line |

## Verification
A wrong rise counter or wrong bit position shows up within a single frame. It appears as a wrong start, opcode or address pattern at the memory model, or as a returned word that is shifted by one bit. The sweep reads every address with a word that differs per address, and the memory model puts a value on the line for the dummy position that differs per address. Because of this, an off-by-one in the turnaround or in the capture window gives a data miscompare on the same request. Divider or handshake faults show at once: a serial period of the wrong length, a gap of the wrong length before `req_ready` returns, or a frame that changes when a request is offered while the block is busy.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } rd_state_e;

  // Read command code, sent after the start bit (first bit on the left).
  localparam logic [1:0] READ_OPC = 2'b10;
endpackage

// File: rtl/spi3w_half_tick.sv
module spi3w_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R8: the half-period counter never passes its terminal value
  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en && $stable(div) |-> cnt_q <= div);
endmodule

// File: rtl/spi3w_tx_shift.sv
module spi3w_tx_shift #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  assign bit_o = sr_q[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  // R5: a load and a shift never coincide
  a_r5_load_xor_shift: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift);
endmodule

// File: rtl/spi3w_rx_shift.sv
module spi3w_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         bit_i,
  output logic [W-1:0] word
);
  logic [W-1:0] sr_q;

  assign word = sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr_q <= '0;
    else if (shift) sr_q <= {sr_q[W-2:0], bit_i};
  end
endmodule

// File: rtl/spi3w_word_reader.sv
module spi3w_word_reader
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  sclk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_cs,
  output logic              mem_sclk,
  output logic              mem_sio_o,
  output logic              mem_sio_oe,
  input  logic              mem_sio_i
);
  localparam int CMD_BITS  = 1 + 2 + ADDR_W;
  localparam int LAST_RISE = CMD_BITS + 1 + DATA_W;
  localparam int RCNT_W    = $clog2(LAST_RISE + 1);
  localparam logic [RCNT_W-1:0] RC_CMD  = RCNT_W'(CMD_BITS);
  localparam logic [RCNT_W-1:0] RC_DAT0 = RCNT_W'(CMD_BITS + 1);
  localparam logic [RCNT_W-1:0] RC_LAST = RCNT_W'(LAST_RISE);

  rd_state_e         state_q;
  logic [RCNT_W-1:0] rcnt_q;
  logic              sclk_q, cs_q, oe_q, rsp_v_q, gap_half_q;
  logic              tick, accept, rise, fall, tx_shift, rx_shift;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign rise     = (state_q == ST_RUN) && tick && !sclk_q;
  assign fall     = (state_q == ST_RUN) && tick &&  sclk_q;
  assign tx_shift = fall && (rcnt_q < RC_CMD);
  assign rx_shift = rise && (rcnt_q >= RC_DAT0);

  spi3w_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(state_q != ST_IDLE),
    .div(sclk_div), .tick(tick)
  );

  spi3w_tx_shift #(.W(CMD_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val({1'b1, READ_OPC, req_addr}),
    .shift(tx_shift), .bit_o(mem_sio_o)
  );

  spi3w_rx_shift #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .shift(rx_shift),
    .bit_i(mem_sio_i), .word(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rcnt_q     <= '0;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b0;
      oe_q       <= 1'b0;
      rsp_v_q    <= 1'b0;
      gap_half_q <= 1'b0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cs_q    <= 1'b1;
            oe_q    <= 1'b1;
            rcnt_q  <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (rise) begin
            sclk_q <= 1'b1;
            rcnt_q <= rcnt_q + 1'b1;
          end else if (fall) begin
            sclk_q <= 1'b0;
            if (rcnt_q == RC_CMD) oe_q <= 1'b0;
            if (rcnt_q == RC_LAST) begin
              cs_q       <= 1'b0;
              rsp_v_q    <= 1'b1;
              gap_half_q <= 1'b0;
              state_q    <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half_q) state_q    <= ST_IDLE;
            else            gap_half_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_v_q;
  assign mem_cs     = cs_q;
  assign mem_sclk   = sclk_q;
  assign mem_sio_oe = oe_q;

  // R8: serial clock idles low outside a frame
  a_r8_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> !mem_sclk);
  // R4: no clock edge without chip select
  a_r4_rise_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sclk) |-> mem_cs);
  // R6: line is driven only inside a frame
  a_r6_oe_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sio_oe |-> mem_cs);
  // R2: no new request taken mid-frame
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> !req_ready);
  // R5: outgoing bit steady across a rising edge
  a_r5_out_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sclk) |-> $stable(mem_sio_o));
  // R9: single-cycle response coinciding with chip select release
  a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_done_drops_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $fell(mem_cs));
endmodule

// File: tb/spi3w_word_reader_tb.sv
module spi3w_word_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sclk_div = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        mem_cs, mem_sclk, mem_sio_o, mem_sio_oe;
  logic        mem_sio_i = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spi3w_word_reader u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_div(sclk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_cs(mem_cs), .mem_sclk(mem_sclk), .mem_sio_o(mem_sio_o),
    .mem_sio_oe(mem_sio_oe), .mem_sio_i(mem_sio_i)
  );

  function automatic logic [15:0] memf(logic [7:0] a);
    logic [15:0] p = 16'(a) * 16'h9E37;
    return p ^ {a, ~a};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Memory model, evaluated on falling system-clock edges
  logic [7:0]  exp_addr = '0;
  logic        ps = 1'b0;
  int          nrise = 0;
  int          since_rise = 0;
  int          cs_age = 0;
  logic [10:0] cmd = '0;
  logic        prev_o = 1'b0;
  logic        idle_clk_err = 1'b0;

  always @(negedge clk) begin
    cyc++;
    since_rise++;
    if (rst_n && !mem_cs && mem_sclk) idle_clk_err = 1'b1;
    if (!mem_cs) begin
      nrise = 0; cmd = '0; mem_sio_i = 1'b0; cs_age = 0;
    end else begin
      cs_age++;
      if (mem_sclk && !ps) begin
        nrise++;
        if (nrise == 1)
          chk(cs_age - 1 >= int'(sclk_div) + 1, "R4 cs lead", cs_age - 1, sclk_div + 1);
        if (nrise == 2 || nrise == 20)
          chk(since_rise == 2 * (int'(sclk_div) + 1), "R8 period", since_rise, 2 * (sclk_div + 1));
        if (nrise <= 11) begin
          if (nrise == 1 || nrise == 11) chk(mem_sio_oe, "R6 oe during cmd", mem_sio_oe, 1);
          if (nrise > 1) chk(mem_sio_o == prev_o, "R5 stable at rise", mem_sio_o, prev_o);
          cmd = {cmd[9:0], mem_sio_o};
        end else if (nrise == 12 || nrise == 28) begin
          chk(!mem_sio_oe, "R6 oe off in data", mem_sio_oe, 0);
        end
        since_rise = 0;
      end else if (!mem_sclk && ps) begin
        if (nrise == 11) begin
          chk(cmd[10:8] == 3'b110, "R3 start+opcode", cmd[10:8], 3'b110);
          chk(cmd[7:0] == exp_addr, "R3 address", cmd[7:0], exp_addr);
          mem_sio_i = ~memf(cmd[7:0])[15] ^ cmd[0];  // dummy position
        end else if (nrise >= 12 && nrise <= 27) begin
          mem_sio_i = memf(cmd[7:0])[27 - nrise];
        end
      end
    end
    ps = mem_sclk;
    prev_o = mem_sio_o;
  end

  task automatic do_read(logic [7:0] a, logic [7:0] dv, bit poke_busy);
    int k;
    sclk_div = dv;
    while (!req_ready) @(negedge clk);
    exp_addr = a;
    req_addr = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && mem_cs, "R2 accepted", {req_ready, mem_cs}, 2'b01);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      req_addr = ~a; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk(!req_ready, "R2 busy ignores", req_ready, 0);
      req_valid = 1'b0; req_addr = a;
    end
    k = 0;
    while (!rsp_valid && k < 2000) begin @(negedge clk); k++; end
    chk(rsp_valid && !mem_cs, "R9 done with cs low", {rsp_valid, mem_cs}, 2'b10);
    chk(rsp_data == memf(a), "R7 word", rsp_data, memf(a));
    k = 0;
    @(negedge clk); k++;
    chk(!rsp_valid, "R9 single pulse", rsp_valid, 0);
    while (!req_ready && k < 2000) begin @(negedge clk); k++; end
    chk(k == 2 * (int'(dv) + 1), "R10 gap", k, 2 * (dv + 1));
    chk(rsp_data == memf(a), "R9 data held", rsp_data, memf(a));
    chk(!idle_clk_err, "R8 sclk idle low", idle_clk_err, 0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_cs && !mem_sclk && !mem_sio_oe && !rsp_valid && req_ready,
        "R1 in reset", {mem_cs, mem_sclk, mem_sio_oe, rsp_valid, req_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_cs && !mem_sclk && !mem_sio_oe && !rsp_valid && req_ready,
        "R1 after reset", {mem_cs, mem_sclk, mem_sio_oe, rsp_valid, req_ready}, 5'b00001);
    for (int a = 0; a < 256; a++) do_read(8'(a), 8'd0, 1'b0);
    for (int a = 0; a < 256; a += 9) do_read(8'(a), 8'd1, 1'b1);
    for (int a = 3; a < 256; a += 37) do_read(8'(a), 8'd4, 1'b1);
    do_read(8'hFF, 8'd2, 1'b0);
    do_read(8'h00, 8'd2, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule